// File: doc/BRIEF.md
# ATA Device Probe and Soft-Reset Sequencer

This block is a hardware state machine that runs the detection and reset steps on a parallel ATA channel. It does not drive the cable itself. It issues single-byte accesses to a PIO register access port and reads the results back from that port.

On a start pulse it works in four steps:

- It selects device 0 and writes a short alternating pattern to the sector-count and LBA-low task-file registers. It reads both registers back and treats a match as a present device. If device 0 does not answer, it tries device 1.
- When a device is found, it reselects device 0 and pulses the soft-reset bit of the device control register. It then waits a long settle time.
- It reads the status register. A floating bus (0xFF) aborts the sequence. Otherwise it waits for the device to become ready:
  - Device 1 is first polled for its reset signature.
  - BSY is then polled, first at a fast rate and then at a slow rate, until it clears or the poll budget runs out.
- It reselects device 0 and pulses done. It reports a two-bit presence mask and an error code.

All waits count microsecond ticks. The ticks come from a clock prescaler, so every delay scales with one parameter. Typical uses are a boot-time bring-up controller or a hot-plug recovery engine.

Top module: `ata_probe_seq`

## Requirements
- R1: After reset, done, dev_mask, err_code and reg_req are all 0. A start pulse is acted on only while the sequencer is idle.
- R2: Selecting a device writes register address 0x6 with 0xA0 for device 0 or 0xB0 for device 1. The next access is then held off for SEL_US microseconds.
- R3: A probe makes six writes that alternate between sector count (address 0x2) and LBA low (address 0x3), starting with sector count. The data is 0x55, 0xAA, 0xAA, 0x55, 0x55, 0xAA. The probe then reads address 0x2 and then address 0x3. The device counts as present only if these reads return 0x55 and 0xAA.
- R4: Device 0 is probed first. Device 1 is probed only when device 0 is absent. dev_mask bit 0 stands for device 0 and bit 1 for device 1, and at most one bit is ever set.
- R5: When neither device answers the probe, the sequence ends with dev_mask 0 and err_code 1 (no device). No device-control write is made.
- R6: The soft reset writes the device control register (address 0xE) three times, with the values 0x08, 0x0C and 0x08. The writes are spaced by SRST_US microseconds. SETTLE_US microseconds follow the last write before the next access.
- R7: If the first status read (address 0x7) after the settle time returns 0xFF, the sequence ends at once with dev_mask 0 and err_code 1.
- R8: For device 1, the sequencer reselects device 1 and reads addresses 0x2 and 0x3 until both return 0x01. Attempts are SLOW_US microseconds apart, with at most DEV1_POLLS attempts. If every attempt fails, the result is dev_mask 0 and err_code 1.
- R9: The BSY wait reads status and tests bit 7.
  - The first FAST_POLLS reads are spaced by FAST_US microseconds, and up to SLOW_POLLS further reads by SLOW_US microseconds.
  - Ready ends the wait with err_code 0. A read of 0xFF gives dev_mask 0 and err_code 1.
  - If BSY is still set on the last read, the result is err_code 2 (busy timeout) and dev_mask is kept.
- R10: Except in the R5 and R7 endings, the last access of a run writes 0xA0 to address 0x6. done is a one-cycle pulse. dev_mask and err_code hold their values until the next start.
- R11: Start pulses during a run are ignored, so each run gives exactly one done. While reg_req waits for reg_ack, reg_we, reg_addr and reg_wdata stay stable.
- R12: Every delay is counted in ticks of TICK_DIV clock cycles each. A delay of N microseconds lasts between N-1 and N ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse to begin a probe-and-reset run |
| reg_req | output | 1 | Register access request, held until acknowledged |
| reg_we | output | 1 | 1 = write, 0 = read |
| reg_addr | output | 4 | Task-file register address |
| reg_wdata | output | 8 | Write data |
| reg_ack | input | 1 | One-cycle completion strobe from the access port |
| reg_rdata | input | 8 | Read data, valid with reg_ack |
| done | output | 1 | One-cycle pulse at the end of a run |
| dev_mask | output | 2 | Device found: bit 0 = device 0, bit 1 = device 1 |
| err_code | output | 2 | 0 none, 1 no device, 2 busy timeout |

## Verification
The assertions assume the access port behaves as follows:
- It raises reg_ack only while a request is pending, and only once per request.
- reg_rdata is valid in the acknowledge cycle.
- It never acknowledges in the cycle right after a previous acknowledge.

The bench responder meets these conditions. It latches each request, answers after a fixed latency and drops reg_ack after one cycle. It emulates two optional devices whose presence, floating status, BSY duration and reset-signature delay are swept over their boundary values. Extra start pulses are injected mid-run to cover the R11 case without breaking the port assumptions.

// File: rtl/ata_probe_pkg.sv
package ata_probe_pkg;

    // task-file addresses seen by the PIO access port
    localparam logic [3:0] TF_NSECT  = 4'h2;
    localparam logic [3:0] TF_LBAL   = 4'h3;
    localparam logic [3:0] TF_DEVICE = 4'h6;
    localparam logic [3:0] TF_STATUS = 4'h7;
    localparam logic [3:0] TF_DEVCTL = 4'hE;

    localparam logic [7:0] SEL_DEV0  = 8'hA0;
    localparam logic [7:0] SEL_DEV1  = 8'hB0;
    localparam logic [7:0] CTL_IDLE  = 8'h08;
    localparam logic [7:0] CTL_SRST  = 8'h0C;
    localparam logic [7:0] PAT_A     = 8'h55;
    localparam logic [7:0] PAT_B     = 8'hAA;
    localparam logic [7:0] BUS_FLOAT = 8'hFF;
    localparam logic [7:0] SIG_ONE   = 8'h01;

    typedef enum logic [1:0] {
        ERR_NONE  = 2'd0,
        ERR_NODEV = 2'd1,
        ERR_BUSY  = 2'd2
    } err_e;

    typedef enum logic [1:0] {
        RET_PATTERN,
        RET_RESET,
        RET_DEV1,
        RET_FINISH
    } ret_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SEL_WR,
        ST_SEL_WAIT,
        ST_PAT_WR,
        ST_PAT_RD_NS,
        ST_PAT_RD_LB,
        ST_RST_WR,
        ST_RST_WAIT,
        ST_SETTLE,
        ST_FLOAT_RD,
        ST_BSY_WAIT,
        ST_BSY_RD,
        ST_D1_RD_NS,
        ST_D1_RD_LB,
        ST_D1_WAIT,
        ST_DONE
    } state_e;

    // probe byte for write step 0..5: 55 AA AA 55 55 AA
    function automatic logic [7:0] probe_byte(input logic [2:0] step);
        return (step[0] ^ (step[2:1] == 2'd1)) ? PAT_B : PAT_A;
    endfunction

endpackage

// File: rtl/ata_us_tick.sv
module ata_us_tick #(
    parameter int TICK_DIV = 50
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int TW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    typedef struct packed {
        logic [TW-1:0] cnt;
        logic          tick;
    } tick_t;

    tick_t q, d;

    always_comb begin
        d      = q;
        d.tick = 1'b0;
        if (q.cnt == TW'(TICK_DIV - 1)) begin
            d.cnt  = '0;
            d.tick = 1'b1;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign tick = q.tick;

    generate
        if (TICK_DIV > 1) begin : g_spacing
            // R12: ticks are separated when the prescaler divides
            assert_tick_spacing_R12: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/ata_delay.sv
module ata_delay #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          load,
    input  logic [DW-1:0] len,
    output logic          fire
);
    typedef struct packed {
        logic [DW-1:0] cnt;
        logic          busy;
        logic          fire;
    } dly_t;

    dly_t q, d;

    always_comb begin
        d      = q;
        d.fire = 1'b0;
        if (load) begin
            d.cnt  = len;
            d.busy = 1'b1;
        end else if (q.busy && tick) begin
            if (q.cnt <= DW'(1)) begin
                d.busy = 1'b0;
                d.fire = 1'b1;
            end else begin
                d.cnt = q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign fire = q.fire;

    // R12: a freshly loaded delay never expires in the next cycle
    assert_load_no_fire_R12: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !fire);
    // R12: expiry is a single-cycle strobe
    assert_fire_once_R12: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire);

endmodule

// File: rtl/ata_probe_seq.sv
module ata_probe_seq
    import ata_probe_pkg::*;
#(
    parameter int TICK_DIV   = 50,
    parameter int SEL_US     = 1,
    parameter int SRST_US    = 20,
    parameter int SETTLE_US  = 150000,
    parameter int FAST_US    = 10,
    parameter int SLOW_US    = 50000,
    parameter int FAST_POLLS = 300,
    parameter int SLOW_POLLS = 200,
    parameter int DEV1_POLLS = 600
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    output logic       reg_req,
    output logic       reg_we,
    output logic [3:0] reg_addr,
    output logic [7:0] reg_wdata,
    input  logic       reg_ack,
    input  logic [7:0] reg_rdata,
    output logic       done,
    output logic [1:0] dev_mask,
    output logic [1:0] err_code
);
    localparam int DLY_A   = (SEL_US > SRST_US) ? SEL_US : SRST_US;
    localparam int DLY_B   = (SETTLE_US > FAST_US) ? SETTLE_US : FAST_US;
    localparam int DLY_C   = (DLY_A > DLY_B) ? DLY_A : DLY_B;
    localparam int DLY_MAX = (DLY_C > SLOW_US) ? DLY_C : SLOW_US;
    localparam int DW      = $clog2(DLY_MAX + 1);
    localparam int POLL_A  = (FAST_POLLS > SLOW_POLLS) ? FAST_POLLS : SLOW_POLLS;
    localparam int POLL_MX = (POLL_A > DEV1_POLLS) ? POLL_A : DEV1_POLLS;
    localparam int PW      = (POLL_MX > 1) ? $clog2(POLL_MX + 1) : 1;

    typedef struct packed {
        state_e        st;
        ret_e          ret;
        logic          dev;
        logic [2:0]    step;
        logic [PW-1:0] poll;
        logic          slow;
        logic [7:0]    ns;
        logic [1:0]    mask;
        err_e          err;
        logic          done;
    } seq_t;

    seq_t q, d;

    logic          tick;
    logic          dly_load;
    logic [DW-1:0] dly_len;
    logic          dly_fire;

    ata_us_tick #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    ata_delay #(.DW(DW)) u_delay (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick),
        .load (dly_load),
        .len  (dly_len),
        .fire (dly_fire)
    );

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        reg_req   = 1'b0;
        reg_we    = 1'b0;
        reg_addr  = '0;
        reg_wdata = '0;
        dly_load  = 1'b0;
        dly_len   = '0;

        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.mask = 2'b00;
                    d.err  = ERR_NONE;
                    d.dev  = 1'b0;
                    d.ret  = RET_PATTERN;
                    d.st   = ST_SEL_WR;
                end
            end

            ST_SEL_WR: begin
                reg_req   = 1'b1;
                reg_we    = 1'b1;
                reg_addr  = TF_DEVICE;
                reg_wdata = q.dev ? SEL_DEV1 : SEL_DEV0;
                if (reg_ack) begin
                    dly_load = 1'b1;
                    dly_len  = DW'(SEL_US);
                    d.st     = ST_SEL_WAIT;
                end
            end

            ST_SEL_WAIT: begin
                if (dly_fire) begin
                    d.step = '0;
                    case (q.ret)
                        RET_PATTERN: d.st = ST_PAT_WR;
                        RET_RESET:   d.st = ST_RST_WR;
                        RET_DEV1:    d.st = ST_D1_RD_NS;
                        default:     d.st = ST_DONE;
                    endcase
                end
            end

            ST_PAT_WR: begin
                reg_req   = 1'b1;
                reg_we    = 1'b1;
                reg_addr  = q.step[0] ? TF_LBAL : TF_NSECT;
                reg_wdata = probe_byte(q.step);
                if (reg_ack) begin
                    if (q.step == 3'd5) d.st = ST_PAT_RD_NS;
                    else                d.step = q.step + 3'd1;
                end
            end

            ST_PAT_RD_NS: begin
                reg_req  = 1'b1;
                reg_addr = TF_NSECT;
                if (reg_ack) begin
                    d.ns = reg_rdata;
                    d.st = ST_PAT_RD_LB;
                end
            end

            ST_PAT_RD_LB: begin
                reg_req  = 1'b1;
                reg_addr = TF_LBAL;
                if (reg_ack) begin
                    if (q.ns == PAT_A && reg_rdata == PAT_B) begin
                        d.mask[q.dev] = 1'b1;
                        d.dev = 1'b0;
                        d.ret = RET_RESET;
                        d.st  = ST_SEL_WR;
                    end else if (!q.dev) begin
                        d.dev = 1'b1;
                        d.ret = RET_PATTERN;
                        d.st  = ST_SEL_WR;
                    end else begin
                        d.err = ERR_NODEV;
                        d.st  = ST_DONE;
                    end
                end
            end

            ST_RST_WR: begin
                reg_req   = 1'b1;
                reg_we    = 1'b1;
                reg_addr  = TF_DEVCTL;
                reg_wdata = (q.step == 3'd1) ? CTL_SRST : CTL_IDLE;
                if (reg_ack) begin
                    dly_load = 1'b1;
                    if (q.step == 3'd2) begin
                        dly_len = DW'(SETTLE_US);
                        d.st    = ST_SETTLE;
                    end else begin
                        dly_len = DW'(SRST_US);
                        d.st    = ST_RST_WAIT;
                    end
                end
            end

            ST_RST_WAIT: begin
                if (dly_fire) begin
                    d.step = q.step + 3'd1;
                    d.st   = ST_RST_WR;
                end
            end

            ST_SETTLE: begin
                if (dly_fire) d.st = ST_FLOAT_RD;
            end

            ST_FLOAT_RD: begin
                reg_req  = 1'b1;
                reg_addr = TF_STATUS;
                if (reg_ack) begin
                    d.poll = '0;
                    if (reg_rdata == BUS_FLOAT) begin
                        d.mask = 2'b00;
                        d.err  = ERR_NODEV;
                        d.st   = ST_DONE;
                    end else if (q.mask[0]) begin
                        d.slow   = 1'b0;
                        dly_load = 1'b1;
                        dly_len  = DW'(FAST_US);
                        d.st     = ST_BSY_WAIT;
                    end else begin
                        d.dev = 1'b1;
                        d.ret = RET_DEV1;
                        d.st  = ST_SEL_WR;
                    end
                end
            end

            ST_BSY_WAIT: begin
                if (dly_fire) d.st = ST_BSY_RD;
            end

            ST_BSY_RD: begin
                reg_req  = 1'b1;
                reg_addr = TF_STATUS;
                if (reg_ack) begin
                    if (reg_rdata == BUS_FLOAT || !reg_rdata[7]) begin
                        if (reg_rdata == BUS_FLOAT) begin
                            d.mask = 2'b00;
                            d.err  = ERR_NODEV;
                        end
                        d.dev = 1'b0;
                        d.ret = RET_FINISH;
                        d.st  = ST_SEL_WR;
                    end else if (!q.slow && q.poll == PW'(FAST_POLLS - 1)) begin
                        d.slow   = 1'b1;
                        d.poll   = '0;
                        dly_load = 1'b1;
                        dly_len  = DW'(SLOW_US);
                        d.st     = ST_BSY_WAIT;
                    end else if (q.slow && q.poll == PW'(SLOW_POLLS - 1)) begin
                        d.err = ERR_BUSY;
                        d.dev = 1'b0;
                        d.ret = RET_FINISH;
                        d.st  = ST_SEL_WR;
                    end else begin
                        d.poll   = q.poll + 1'b1;
                        dly_load = 1'b1;
                        dly_len  = q.slow ? DW'(SLOW_US) : DW'(FAST_US);
                        d.st     = ST_BSY_WAIT;
                    end
                end
            end

            ST_D1_RD_NS: begin
                reg_req  = 1'b1;
                reg_addr = TF_NSECT;
                if (reg_ack) begin
                    d.ns = reg_rdata;
                    d.st = ST_D1_RD_LB;
                end
            end

            ST_D1_RD_LB: begin
                reg_req  = 1'b1;
                reg_addr = TF_LBAL;
                if (reg_ack) begin
                    if (q.ns == SIG_ONE && reg_rdata == SIG_ONE) begin
                        d.poll   = '0;
                        d.slow   = 1'b0;
                        dly_load = 1'b1;
                        dly_len  = DW'(FAST_US);
                        d.st     = ST_BSY_WAIT;
                    end else if (q.poll == PW'(DEV1_POLLS - 1)) begin
                        d.mask = 2'b00;
                        d.err  = ERR_NODEV;
                        d.dev  = 1'b0;
                        d.ret  = RET_FINISH;
                        d.st   = ST_SEL_WR;
                    end else begin
                        d.poll   = q.poll + 1'b1;
                        dly_load = 1'b1;
                        dly_len  = DW'(SLOW_US);
                        d.st     = ST_D1_WAIT;
                    end
                end
            end

            ST_D1_WAIT: begin
                if (dly_fire) d.st = ST_SEL_WR;
            end

            default: begin
                d.done = 1'b1;
                d.st   = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.ret  <= RET_PATTERN;
            q.err  <= ERR_NONE;
        end else begin
            q <= d;
        end
    end

    assign done     = q.done;
    assign dev_mask = q.mask;
    assign err_code = q.err;

    // R11: a pending request keeps its command until acknowledged
    assert_req_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && !reg_ack) |=> (reg_req && $stable(reg_we) && $stable(reg_addr) && $stable(reg_wdata)));
    // R4: never more than one device recorded
    assert_single_dev_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dev_mask));
    // R9: a busy timeout is only reported for a recorded device
    assert_busy_has_dev_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err_code == ERR_BUSY) |-> (dev_mask != 2'b00));
    // R5: a no-device report carries an empty mask
    assert_nodev_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err_code == ERR_NODEV) |-> (dev_mask == 2'b00));
    // R6: the control register only ever sees the idle or reset value
    assert_ctl_values_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && reg_we && reg_addr == TF_DEVCTL) |-> (reg_wdata == CTL_IDLE || reg_wdata == CTL_SRST));
    // R10: done is a single-cycle pulse with no access pending
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R12: delay expiry arrives only while the sequencer is waiting on it
    assert_fire_in_wait_R12: assert property (@(posedge clk) disable iff (!rst_n)
        dly_fire |-> (q.st == ST_SEL_WAIT || q.st == ST_RST_WAIT || q.st == ST_SETTLE ||
                      q.st == ST_BSY_WAIT || q.st == ST_D1_WAIT));

endmodule

// File: tb/ata_probe_seq_test.sv
module ata_probe_seq_test;
    localparam int DIV = 2, SEL = 2, SRST = 3, SETTLE = 20, FAST = 2, SLOW = 5;
    localparam int FP = 3, SP = 2, DP = 3;

    logic       clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic       reg_req, reg_we, reg_ack, done;
    logic [3:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;
    logic [1:0] dev_mask, err_code;

    ata_probe_seq #(
        .TICK_DIV(DIV), .SEL_US(SEL), .SRST_US(SRST), .SETTLE_US(SETTLE),
        .FAST_US(FAST), .SLOW_US(SLOW), .FAST_POLLS(FP), .SLOW_POLLS(SP), .DEV1_POLLS(DP)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_ack(reg_ack), .reg_rdata(reg_rdata),
        .done(done), .dev_mask(dev_mask), .err_code(err_code)
    );

    always #10 clk = ~clk;

    int n_chk = 0, n_err = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // device model configuration
    logic [1:0] m_pres = 2'b00;
    bit         m_float = 1'b0;
    int         m_bsy = 0, m_d1w = 0;

    // device model state
    logic [7:0] m_ns [2];
    logic [7:0] m_lb [2];
    logic       m_sel, m_busy, m_rst_seen;
    int         m_lat, m_bsy_left, m_d1_left;
    logic       m_we;
    logic [3:0] m_addr;
    logic [7:0] m_wd;
    int         n_done;

    // access log
    int         nlog;
    logic [3:0] l_addr [64];
    logic       l_we   [64];
    logic [7:0] l_data [64];
    int         l_ts   [64];
    int         l_ta   [64];

    always @(posedge clk or negedge rst_n) begin
        logic [7:0] r;
        if (!rst_n) begin
            reg_ack <= 1'b0; reg_rdata <= 8'h00;
            m_busy <= 1'b0; m_sel <= 1'b0; m_rst_seen <= 1'b0; m_lat <= 0;
            m_ns[0] <= 8'h00; m_ns[1] <= 8'h00; m_lb[0] <= 8'h00; m_lb[1] <= 8'h00;
            m_bsy_left <= m_bsy; m_d1_left <= m_d1w; nlog <= 0; n_done <= 0;
        end else begin
            if (done) n_done <= n_done + 1;
            if (reg_ack) begin
                reg_ack <= 1'b0;
            end else if (reg_req && !m_busy) begin
                m_busy <= 1'b1; m_lat <= 1;
                m_we <= reg_we; m_addr <= reg_addr; m_wd <= reg_wdata;
                if (nlog < 64) l_ts[nlog] <= cyc;
            end else if (m_busy) begin
                if (m_lat > 0) begin
                    m_lat <= m_lat - 1;
                end else begin
                    m_busy <= 1'b0;
                    reg_ack <= 1'b1;
                    r = 8'h00;
                    if (m_we) begin
                        r = m_wd;
                        case (m_addr)
                            4'h6: m_sel <= m_wd[4];
                            4'h2: if (m_pres[m_sel]) m_ns[m_sel] <= m_wd;
                            4'h3: if (m_pres[m_sel]) m_lb[m_sel] <= m_wd;
                            4'hE: if (m_wd[2]) begin
                                m_ns[0] <= 8'h01; m_ns[1] <= 8'h01;
                                m_lb[0] <= 8'h01; m_lb[1] <= 8'h01;
                                m_rst_seen <= 1'b1;
                            end
                            default: ;
                        endcase
                    end else begin
                        case (m_addr)
                            4'h2: begin
                                if (!m_pres[m_sel]) r = 8'hFF;
                                else if (m_sel && m_rst_seen && m_d1_left > 0) begin
                                    r = 8'h00; m_d1_left <= m_d1_left - 1;
                                end else r = m_ns[m_sel];
                            end
                            4'h3: r = m_pres[m_sel] ? m_lb[m_sel] : 8'hFF;
                            4'h7: begin
                                if (m_float) r = 8'hFF;
                                else if (m_bsy_left > 0) begin
                                    r = 8'h80; m_bsy_left <= m_bsy_left - 1;
                                end else r = 8'h50;
                            end
                            default: r = 8'hFF;
                        endcase
                        reg_rdata <= r;
                    end
                    if (nlog < 64) begin
                        l_addr[nlog] <= m_addr; l_we[nlog] <= m_we;
                        l_data[nlog] <= r; l_ta[nlog] <= cyc;
                        nlog <= nlog + 1;
                    end
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic gap_chk(input string req, input int g, input int len);
        chk(g >= (len - 1) * DIV && g <= (len + 1) * DIV + 6, req, g, len * DIV);
    endtask

    task automatic run_case(input int p, input int f, input int b, input int dw, input bit first);
        int t, ectl, emask, eerr, bw;
        int ci [3];
        logic [1:0] hm, he;
        logic [7:0] pat [6];
        pat = '{8'h55, 8'hAA, 8'hAA, 8'h55, 8'h55, 8'hAA};
        m_pres = p[1:0]; m_float = f[0]; m_bsy = b; m_d1w = dw;
        @(negedge clk) rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        if (first) begin
            chk(done == 1'b0 && reg_req == 1'b0, "R1 reset done/req", {done, reg_req}, 0);
            chk(dev_mask == 2'b00, "R1 reset mask", dev_mask, 0);
            chk(err_code == 2'b00, "R1 reset err", err_code, 0);
        end
        start = 1'b1; @(negedge clk) start = 1'b0;
        repeat (4) @(negedge clk);
        start = 1'b1; @(negedge clk) start = 1'b0;   // R11: ignored while running
        t = 0;
        while (!done && t < 6000) begin @(negedge clk); t++; end
        chk(t < 6000, "R10 done reached", t, 6000);
        hm = dev_mask; he = err_code;

        // expected outcome
        if (p == 0) begin emask = 0; eerr = 1; end
        else begin
            emask = p[0] ? 1 : 2;
            bw = (b > 0) ? b - 1 : 0;
            if (f != 0) begin emask = 0; eerr = 1; end
            else if (emask == 2 && dw >= DP) begin emask = 0; eerr = 1; end
            else if (bw >= FP + SP) eerr = 2;
            else eerr = 0;
        end
        chk(hm == emask[1:0], $sformatf("R4 R5 R7 R8 R9 mask p%0d f%0d b%0d d%0d", p, f, b, dw), hm, emask);
        chk(he == eerr[1:0], $sformatf("R5 R7 R8 R9 err p%0d f%0d b%0d d%0d", p, f, b, dw), he, eerr);

        // R2/R3: select and probe pattern for device 0
        chk(l_addr[0] == 4'h6 && l_we[0] && l_data[0] == 8'hA0, "R2 first select", l_data[0], 8'hA0);
        if (nlog > 1) gap_chk("R2 select wait", l_ts[1] - l_ta[0], SEL);
        begin
            bit ok = 1'b1;
            for (int k = 0; k < 6; k++)
                if (!(l_we[k+1] && l_addr[k+1] == ((k % 2) ? 4'h3 : 4'h2) && l_data[k+1] == pat[k])) ok = 1'b0;
            if (!(!l_we[7] && l_addr[7] == 4'h2 && !l_we[8] && l_addr[8] == 4'h3)) ok = 1'b0;
            chk(ok, "R3 probe pattern", l_data[1], 8'h55);
        end
        if (!p[0]) chk(l_addr[9] == 4'h6 && l_we[9] && l_data[9] == 8'hB0, "R4 device 1 select", l_data[9], 8'hB0);

        // R6: soft reset sequence
        ectl = 0;
        for (int k = 0; k < nlog; k++)
            if (l_we[k] && l_addr[k] == 4'hE) begin
                if (ectl < 3) ci[ectl] = k;
                ectl++;
            end
        chk(ectl == ((p == 0) ? 0 : 3), "R5 R6 control write count", ectl, (p == 0) ? 0 : 3);
        if (p != 0 && ectl == 3) begin
            chk(l_data[ci[0]] == 8'h08 && l_data[ci[1]] == 8'h0C && l_data[ci[2]] == 8'h08,
                "R6 control values", {l_data[ci[0]], l_data[ci[1]], l_data[ci[2]]}, 24'h080C08);
            gap_chk("R6 R12 SRST spacing", l_ts[ci[1]] - l_ta[ci[0]], SRST);
            gap_chk("R6 R12 settle wait", l_ts[ci[2] + 1] - l_ta[ci[2]], SETTLE);
        end

        // endings
        if (p == 0)
            chk(!l_we[nlog-1] && l_addr[nlog-1] == 4'h3, "R5 ends after probe", l_addr[nlog-1], 3);
        else if (f != 0)
            chk(!l_we[nlog-1] && l_addr[nlog-1] == 4'h7 && nlog - 1 == ci[2] + 1, "R7 ends at float read",
                l_addr[nlog-1], 7);
        else
            chk(l_we[nlog-1] && l_addr[nlog-1] == 4'h6 && l_data[nlog-1] == 8'hA0, "R10 final reselect",
                l_data[nlog-1], 8'hA0);

        repeat (20) @(negedge clk);
        chk(n_done == 1, "R11 single done", n_done, 1);
        chk(dev_mask == hm && err_code == he, "R10 outputs hold", {dev_mask, err_code}, {hm, he});
    endtask

    initial begin
        int bset [6];
        int dset [3];
        bit first = 1'b1;
        bset = '{0, 1, 3, 5, 6, 8};
        dset = '{0, 2, 3};
        for (int p = 0; p < 4; p++)
            for (int f = 0; f < 2; f++)
                for (int bi = 0; bi < 6; bi++)
                    for (int di = 0; di < 3; di++) begin
                        if (p == 0 && (f != 0 || bi != 0 || di != 0)) continue;
                        if (p != 2 && di != 0) continue;
                        run_case(p, f, bset[bi], dset[di], first);
                        first = 1'b0;
                    end
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule